// File: doc/BRIEF.md
# Interruption State Registers

This block keeps three 64-bit control registers that hold what the processor knows when an interruption is taken: a function-state register (a saved frame marker plus a valid flag), an immediate register that receives the immediate or cause value tied to the fault, and a hash-address register that receives the translation-table entry address used to resolve a translation fault. Privileged software reads and writes the registers through one register port. That port carries the current privilege level and the interruption-collection flag, and the block raises a privileged-operation fault or an illegal-operation fault when the access is not allowed.

Interruption events come from the fault logic. Each event carries a fault kind, an immediate field, a 64-bit intercept cause and a table-entry address. A cover request carries the current frame marker and saves it into the function-state register. The saved marker and its valid flag go straight out to the return-from-interruption path. Reads are combinational in the access cycle. All register updates happen on the next rising clock edge.

Top module: `intr_state_regs`

## Requirements
- R1: After reset, all three registers read as zero, and the return-path frame and valid outputs are zero.
- R2: An access with privilege level other than 0 raises `flt_priv` in the same cycle and never `flt_illegal`. Its read data is zero and its write has no effect.
- R3: An access at privilege level 0 with the collection flag at 1 raises `flt_illegal`. Its read data is zero and its write has no effect.
- R4: An access at privilege level 0 with the collection flag at 0 raises no fault. It returns the selected register in the same cycle, and a write lands at the next edge. The select codes are 0 function-state, 1 immediate, 2 hash address and 3 none; code 3 reads zero and writes nothing.
- R5: In the function-state register, bits 37:0 hold the frame marker, bit 63 holds the valid flag, and bits 62:38 read as zero with written values discarded.
- R6: An interruption event with the collection flag at 1 clears the valid flag and leaves the frame marker unchanged.
- R7: A cover request with the collection flag at 0 copies `cov_frame` into the frame marker and sets the valid flag. A cover request with the flag at 1 is ignored.
- R8: Event kinds 1 (check) and 2 (break) load the immediate register with `evt_imm` zero-extended to 64 bits. Kind 0 and kinds 5 to 7 leave it unchanged.
- R9: Event kind 3 (branch-form break) loads zero into the immediate register, whatever `evt_imm` holds.
- R10: Event kind 4 (intercept) loads all 64 bits of `evt_cause` into the immediate register.
- R11: An event with the collection flag at 1 loads bits 63:2 of `evt_hash_addr` into the hash-address register. An event with the flag at 0 leaves it unchanged. Bits 1:0 always read zero, and software writes to them are dropped.
- R12: A software write in the same cycle as any interruption event is discarded. A cover request that takes effect overrides a same-cycle software write to the function-state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_sel | input | 2 | Register select (0 function-state, 1 immediate, 2 hash, 3 none) |
| acc_priv | input | 2 | Privilege level of the access |
| ic_on | input | 1 | Interruption-collection flag |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data, zero unless the access is allowed |
| flt_illegal | output | 1 | Illegal-operation fault |
| flt_priv | output | 1 | Privileged-operation fault |
| evt_valid | input | 1 | Interruption event this cycle |
| evt_kind | input | 3 | Fault kind of the event |
| evt_imm | input | 21 | Immediate field of the faulting instruction |
| evt_cause | input | 64 | Intercept cause value |
| evt_hash_addr | input | 64 | Translation-table entry address |
| cov_valid | input | 1 | Cover request |
| cov_frame | input | 38 | Current frame marker for the cover request |
| rfi_frame | output | 38 | Saved frame marker for the return path |
| rfi_valid | output | 1 | Saved frame marker valid |

## Verification
The hardest case to reach from the ports is a collision: an allowed software write, an interruption event and a cover request all in one cycle, with the collection flag at 0 so that every update path is live. Random traffic rarely lines these up with an allowed privilege level. The bench therefore drives each collision directly, then reads the registers back through the port. A long random run follows in which events, covers and accesses overlap freely, and a bench model predicts every read and every return-path value.

// File: rtl/intr_state_pkg.sv
// Package: shared encodings for the interruption state registers.
// Assumes: a select code and a fault-kind code arrive as plain vectors at the top.
package intr_state_pkg;

    typedef enum logic [1:0] {
        SEL_FSTATE = 2'd0,
        SEL_IMMED  = 2'd1,
        SEL_HASH   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        EVK_PLAIN     = 3'd0,
        EVK_CHECK     = 3'd1,
        EVK_BREAK     = 3'd2,
        EVK_BR_BREAK  = 3'd3,
        EVK_INTERCEPT = 3'd4
    } evt_kind_e;

endpackage

// File: rtl/ist_access_check.sv
// Module: decides whether a register-port access is allowed or faults.
// Assumes: privilege level 0 is the most privileged level. A privilege
// failure hides a collection-flag failure.
module ist_access_check #(
    parameter int PRIV_W = 2
) (
    input  logic              acc_valid,
    input  logic [PRIV_W-1:0] acc_priv,
    input  logic              ic_on,
    output logic              flt_priv,
    output logic              flt_illegal,
    output logic              acc_ok
);
    logic top_level;

    // Classify the access into privileged fault, illegal fault or allowed.
    always_comb begin
        top_level   = (acc_priv == '0);
        flt_priv    = acc_valid && !top_level;
        flt_illegal = acc_valid && top_level && ic_on;
        acc_ok      = acc_valid && top_level && !ic_on;
    end
endmodule

// File: rtl/ist_imm_next.sv
// Module: computes the immediate-register load caused by an interruption event.
// Assumes: evt_kind follows evt_kind_e; unknown kinds leave the register alone.
module ist_imm_next
    import intr_state_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 21
) (
    input  logic              evt_valid,
    input  logic [2:0]        evt_kind,
    input  logic [IMM_W-1:0]  evt_imm,
    input  logic [DATA_W-1:0] evt_cause,
    output logic              imm_load,
    output logic [DATA_W-1:0] imm_value
);
    localparam int PAD_W = DATA_W - IMM_W;

    // Select the new immediate value from the fault kind.
    always_comb begin
        imm_load  = 1'b0;
        imm_value = '0;
        if (evt_valid) begin
            case (evt_kind_e'(evt_kind))
                EVK_CHECK, EVK_BREAK: begin
                    imm_load  = 1'b1;
                    imm_value = {{PAD_W{1'b0}}, evt_imm};
                end
                EVK_BR_BREAK: begin
                    imm_load  = 1'b1;
                    imm_value = '0;
                end
                EVK_INTERCEPT: begin
                    imm_load  = 1'b1;
                    imm_value = evt_cause;
                end
                default: begin
                    imm_load  = 1'b0;
                    imm_value = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/ist_fs_update.sv
// Module: next-state logic of the function-state register (frame marker, valid flag).
// Assumes: wr_fs is already cleared when an event or a fault blocks the write.
// Order: event clear, then cover, then software write.
module ist_fs_update #(
    parameter int FRAME_W = 38
) (
    input  logic               evt_valid,
    input  logic               ic_on,
    input  logic               cov_valid,
    input  logic [FRAME_W-1:0] cov_frame,
    input  logic               wr_fs,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_valid,
    input  logic [FRAME_W-1:0] frame_q,
    input  logic               valid_q,
    output logic [FRAME_W-1:0] frame_d,
    output logic               valid_d
);
    // Pick the function-state update source by priority.
    always_comb begin
        frame_d = frame_q;
        valid_d = valid_q;
        if (evt_valid && ic_on) begin
            valid_d = 1'b0;
        end else if (cov_valid && !ic_on) begin
            frame_d = cov_frame;
            valid_d = 1'b1;
        end else if (wr_fs) begin
            frame_d = wr_frame;
            valid_d = wr_valid;
        end
    end
endmodule

// File: rtl/intr_state_regs.sv
// Module: the three interruption state registers with their access port,
// event updates, cover request and return-path outputs.
// Assumes: synchronous active-low reset; reads are combinational, writes take effect
// at the next edge. An event in a cycle drops that cycle's software write.
module intr_state_regs
    import intr_state_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int FRAME_W  = 38,
    parameter int IMM_W    = 21,
    parameter int PRIV_W   = 2,
    parameter int HASH_LSB = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [1:0]         acc_sel,
    input  logic [PRIV_W-1:0]  acc_priv,
    input  logic               ic_on,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic [DATA_W-1:0]  acc_rdata,
    output logic               flt_illegal,
    output logic               flt_priv,
    input  logic               evt_valid,
    input  logic [2:0]         evt_kind,
    input  logic [IMM_W-1:0]   evt_imm,
    input  logic [DATA_W-1:0]  evt_cause,
    input  logic [DATA_W-1:0]  evt_hash_addr,
    input  logic               cov_valid,
    input  logic [FRAME_W-1:0] cov_frame,
    output logic [FRAME_W-1:0] rfi_frame,
    output logic               rfi_valid
);
    localparam int RSV_W  = DATA_W - 1 - FRAME_W;
    localparam int HASH_W = DATA_W - HASH_LSB;

    logic               acc_ok;
    logic               wr_en, wr_fs, wr_imm, wr_hash;
    logic [FRAME_W-1:0] fs_frame_q, fs_frame_d;
    logic               fs_valid_q, fs_valid_d;
    logic [DATA_W-1:0]  imm_q, imm_value;
    logic               imm_load;
    logic [HASH_W-1:0]  hash_q;
    logic               unused_bits;

    assign unused_bits = ^{evt_hash_addr[HASH_LSB-1:0], acc_wdata[HASH_LSB-1:0],
                           acc_wdata[DATA_W-2:FRAME_W]};

    ist_access_check #(.PRIV_W(PRIV_W)) u_acc (
        .acc_valid   (acc_valid),
        .acc_priv    (acc_priv),
        .ic_on       (ic_on),
        .flt_priv    (flt_priv),
        .flt_illegal (flt_illegal),
        .acc_ok      (acc_ok)
    );

    // Gate software writes: allowed access, write, no event in the same cycle.
    always_comb begin
        wr_en   = acc_ok && acc_write && !evt_valid;
        wr_fs   = wr_en && (reg_sel_e'(acc_sel) == SEL_FSTATE);
        wr_imm  = wr_en && (reg_sel_e'(acc_sel) == SEL_IMMED);
        wr_hash = wr_en && (reg_sel_e'(acc_sel) == SEL_HASH);
    end

    ist_imm_next #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_imm (
        .evt_valid (evt_valid),
        .evt_kind  (evt_kind),
        .evt_imm   (evt_imm),
        .evt_cause (evt_cause),
        .imm_load  (imm_load),
        .imm_value (imm_value)
    );

    ist_fs_update #(.FRAME_W(FRAME_W)) u_fs (
        .evt_valid (evt_valid),
        .ic_on     (ic_on),
        .cov_valid (cov_valid),
        .cov_frame (cov_frame),
        .wr_fs     (wr_fs),
        .wr_frame  (acc_wdata[FRAME_W-1:0]),
        .wr_valid  (acc_wdata[DATA_W-1]),
        .frame_q   (fs_frame_q),
        .valid_q   (fs_valid_q),
        .frame_d   (fs_frame_d),
        .valid_d   (fs_valid_d)
    );

    // Function-state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_frame_q <= '0;
            fs_valid_q <= 1'b0;
        end else begin
            fs_frame_q <= fs_frame_d;
            fs_valid_q <= fs_valid_d;
        end
    end

    // Immediate register: event load first, software write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imm_q <= '0;
        end else if (imm_load) begin
            imm_q <= imm_value;
        end else if (wr_imm) begin
            imm_q <= acc_wdata;
        end
    end

    // Hash-address register, upper bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hash_q <= '0;
        end else if (evt_valid && ic_on) begin
            hash_q <= evt_hash_addr[DATA_W-1:HASH_LSB];
        end else if (wr_hash) begin
            hash_q <= acc_wdata[DATA_W-1:HASH_LSB];
        end
    end

    // Read mux: selected register view, zero unless the access is allowed.
    always_comb begin
        acc_rdata = '0;
        if (acc_ok) begin
            case (reg_sel_e'(acc_sel))
                SEL_FSTATE: acc_rdata = {fs_valid_q, {RSV_W{1'b0}}, fs_frame_q};
                SEL_IMMED:  acc_rdata = imm_q;
                SEL_HASH:   acc_rdata = {hash_q, {HASH_LSB{1'b0}}};
                default:    acc_rdata = '0;
            endcase
        end
    end

    assign rfi_frame = fs_frame_q;
    assign rfi_valid = fs_valid_q;
endmodule

// File: rtl/ist_checker.sv
// Module: assertion checker for intr_state_regs, attached by bind.
// Assumes: it observes the top-level ports only.
module ist_checker #(
    parameter int DATA_W  = 64,
    parameter int FRAME_W = 38,
    parameter int PRIV_W  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic [1:0]         acc_sel,
    input logic [PRIV_W-1:0]  acc_priv,
    input logic               ic_on,
    input logic [DATA_W-1:0]  acc_rdata,
    input logic               flt_illegal,
    input logic               flt_priv,
    input logic               evt_valid,
    input logic               cov_valid,
    input logic [FRAME_W-1:0] cov_frame,
    input logic [FRAME_W-1:0] rfi_frame,
    input logic               rfi_valid
);
    // R2
    priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_priv != '0) |-> (flt_priv && !flt_illegal && acc_rdata == '0));

    // R3
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_illegal |-> (acc_rdata == '0 && !flt_priv));

    // R2
    fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flt_priv || flt_illegal) && !evt_valid && !cov_valid) |=> $stable(rfi_frame));

    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_sel == 2'd0) |-> (acc_rdata[DATA_W-2:FRAME_W] == '0));

    // R6
    valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && ic_on) |=> !rfi_valid);

    // R7
    cover_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cov_valid && !ic_on) |=> (rfi_valid && rfi_frame == $past(cov_frame)));

    // R11
    hash_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_sel == 2'd2) |-> (acc_rdata[1:0] == 2'b00));
endmodule

bind intr_state_regs ist_checker #(
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .PRIV_W  (PRIV_W)
) u_ist_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_sel     (acc_sel),
    .acc_priv    (acc_priv),
    .ic_on       (ic_on),
    .acc_rdata   (acc_rdata),
    .flt_illegal (flt_illegal),
    .flt_priv    (flt_priv),
    .evt_valid   (evt_valid),
    .cov_valid   (cov_valid),
    .cov_frame   (cov_frame),
    .rfi_frame   (rfi_frame),
    .rfi_valid   (rfi_valid)
);

// File: tb/tb_intr_state_regs.sv
// Bench: directed corner cases, then seeded random traffic checked against a bench model.
module tb_intr_state_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, ic_on = 1'b0;
    logic [1:0]  acc_sel = '0, acc_priv = '0;
    logic [63:0] acc_wdata = '0, acc_rdata, evt_cause = '0, evt_hash_addr = '0;
    logic        flt_illegal, flt_priv, evt_valid = 1'b0, cov_valid = 1'b0, rfi_valid;
    logic [2:0]  evt_kind = '0;
    logic [20:0] evt_imm = '0;
    logic [37:0] cov_frame = '0, rfi_frame;

    int errors = 0;
    int checks = 0;

    // bench model
    logic [37:0] m_frame = '0;
    logic        m_v = 1'b0;
    logic [63:0] m_imm = '0, m_hash = '0;

    always #10 clk = ~clk;

    intr_state_regs dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_sel(acc_sel), .acc_priv(acc_priv), .ic_on(ic_on), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .flt_illegal(flt_illegal), .flt_priv(flt_priv),
        .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_imm(evt_imm),
        .evt_cause(evt_cause), .evt_hash_addr(evt_hash_addr), .cov_valid(cov_valid),
        .cov_frame(cov_frame), .rfi_frame(rfi_frame), .rfi_valid(rfi_valid)
    );

    function automatic logic [63:0] view(input logic [1:0] sel);
        case (sel)
            2'd0:    return {m_v, 25'd0, m_frame};
            2'd1:    return m_imm;
            2'd2:    return m_hash;
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        acc_valid = 0; acc_write = 0; acc_sel = 0; acc_priv = 0; ic_on = 0;
        acc_wdata = 0; evt_valid = 0; evt_kind = 0; evt_imm = 0; evt_cause = 0;
        evt_hash_addr = 0; cov_valid = 0; cov_frame = 0;
    endtask

    // one cycle: inputs already driven after a negedge; check, clock, update model
    task automatic step(input string rd_tag);
        logic ok, wr;
        #2;
        ok = acc_valid && acc_priv == 0 && !ic_on;
        check("R2 flt_priv", {63'd0, flt_priv}, {63'd0, acc_valid && acc_priv != 0});
        check("R3 flt_illegal", {63'd0, flt_illegal}, {63'd0, acc_valid && acc_priv == 0 && ic_on});
        check(rd_tag, acc_rdata, ok ? view(acc_sel) : 64'd0);
        check("R7 rfi_frame", {26'd0, rfi_frame}, {26'd0, m_frame});
        check("R6 rfi_valid", {63'd0, rfi_valid}, {63'd0, m_v});
        @(posedge clk);
        wr = ok && acc_write && !evt_valid;
        if (evt_valid && (evt_kind == 1 || evt_kind == 2)) m_imm = {43'd0, evt_imm};
        else if (evt_valid && evt_kind == 3) m_imm = 64'd0;
        else if (evt_valid && evt_kind == 4) m_imm = evt_cause;
        else if (wr && acc_sel == 1) m_imm = acc_wdata;
        if (evt_valid && ic_on) m_hash = {evt_hash_addr[63:2], 2'b00};
        else if (wr && acc_sel == 2) m_hash = {acc_wdata[63:2], 2'b00};
        if (evt_valid && ic_on) m_v = 1'b0;
        else if (cov_valid && !ic_on) begin m_frame = cov_frame; m_v = 1'b1; end
        else if (wr && acc_sel == 0) begin m_frame = acc_wdata[37:0]; m_v = acc_wdata[63]; end
        @(negedge clk);
        idle();
    endtask

    task automatic acc(input logic w, input logic [1:0] sel, input logic [1:0] pl,
                       input logic ic, input logic [63:0] d);
        acc_valid = 1; acc_write = w; acc_sel = sel; acc_priv = pl; ic_on = ic; acc_wdata = d;
    endtask

    task automatic rd(input logic [1:0] sel, input string tag);
        acc(0, sel, 0, 0, 0);
        step(tag);
    endtask

    task automatic ev(input logic ic, input logic [2:0] k, input logic [20:0] im,
                      input logic [63:0] cause, input logic [63:0] addr);
        evt_valid = 1; ic_on = ic; evt_kind = k; evt_imm = im; evt_cause = cause;
        evt_hash_addr = addr;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd2718));
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: zero after reset
        rd(0, "R1 fstate"); rd(1, "R1 immed"); rd(2, "R1 hash"); rd(3, "R1 none");
        // R5: reserved bits discarded
        acc(1, 0, 0, 0, '1); step("R5 write");
        rd(0, "R5 layout");
        check("R5 direct", view(0), 64'h8000_003F_FFFF_FFFF);
        // R2: privileged writes ignored
        acc(1, 1, 2'd3, 0, 64'h1234); step("R2 write");
        rd(1, "R2 immed unchanged");
        acc(0, 2, 2'd1, 1, 0); step("R2 both fail");
        // R3: collection flag blocks
        acc(1, 1, 0, 1, 64'h55); step("R3 write");
        rd(1, "R3 immed unchanged");
        // R6: event clears valid
        ev(1, 0, 0, 0, 64'h0); step("R6 event");
        rd(0, "R6 fstate");
        // R7: cover copies, ignored at ic=1
        cov_valid = 1; cov_frame = 38'h2A_5A5A_5A5A; step("R7 cover");
        rd(0, "R7 fstate");
        cov_valid = 1; ic_on = 1; cov_frame = 38'h11; step("R7 cover ic1");
        rd(0, "R7 fstate ignored");
        // R8: zero-extension
        ev(0, 1, 21'h1FFFFF, '1, 0); step("R8 check ev");
        rd(1, "R8 check");
        check("R8 direct", m_imm, 64'h1F_FFFF);
        ev(0, 2, 21'h00ABC, '1, 0); step("R8 break ev");
        rd(1, "R8 break");
        ev(0, 6, 21'h3, 64'h9, 0); step("R8 unknown kind");
        rd(1, "R8 kept");
        // R9: branch break writes zero
        ev(0, 3, 21'h1FFFFF, '1, 0); step("R9 ev");
        rd(1, "R9 zero");
        // R10: intercept cause
        ev(0, 4, 21'h1, 64'hDEAD_BEEF_0BAD_F00D, 0); step("R10 ev");
        rd(1, "R10 cause");
        // R11: hash address
        ev(1, 0, 0, 0, 64'hFEDC_BA98_7654_3213); step("R11 ev");
        rd(2, "R11 hash");
        ev(0, 0, 0, 0, 64'h1111_1111_1111_1111); step("R11 ev ic0");
        rd(2, "R11 hash kept");
        acc(1, 2, 0, 0, 64'h0123_4567_89AB_CDEF); step("R11 write");
        rd(2, "R11 hash written");
        // R12: event drops write, cover beats write
        acc(1, 1, 0, 0, 64'hAAAA); ev(0, 0, 0, 0, 0); step("R12 collide");
        rd(1, "R12 immed kept");
        acc(1, 0, 0, 0, 64'h0000_0000_0000_0077); cov_valid = 1;
        cov_frame = 38'h3C; step("R12 cover");
        rd(0, "R12 fstate cover");
        acc(1, 0, 0, 0, 64'h9); cov_valid = 1; cov_frame = 38'h5;
        ev(0, 4, 0, 64'h42, 0); step("R12 triple");
        rd(0, "R12 fstate"); rd(1, "R12 immed");
        // R4: random traffic
        for (int i = 0; i < 4000; i++) begin
            r = $urandom;
            acc_valid = r[0] | r[1];
            acc_write = r[2];
            acc_sel = r[4:3];
            acc_priv = (r[7:5] == 0) ? r[9:8] : 2'd0;
            ic_on = (r[11:10] == 0);
            acc_wdata = {$urandom, $urandom};
            evt_valid = (r[14:12] == 0);
            evt_kind = r[17:15];
            r = $urandom;
            evt_imm = r[20:0];
            evt_cause = {$urandom, $urandom};
            evt_hash_addr = {$urandom, $urandom};
            cov_valid = (r[23:21] == 0);
            cov_frame = {r[29:24], $urandom};
            step("R4 rdata");
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule